// File: doc/BRIEF.md
# Embedded-Clock Word Framer

This block turns a stream of 10-bit parallel words into a single serial line. Every frame wraps one word between two framing bits. A high start bit comes first, then the ten data bits with the least significant bit first, then a low stop bit. The guaranteed low-to-high edge at each frame boundary lets a receiver find word alignment and recover timing without a separate clock wire. One bit leaves per cycle in which the bit-rate enable is high. A frame therefore takes twelve enabled cycles.

Two sync request inputs are provided, and either one is enough. While a request is high at a frame boundary, the block sends a fixed sync frame instead of the user word. A receiver's active-high "not aligned" flag can be fed straight back into a request input. Sync frames then keep flowing until the receiver has aligned. The data word and both requests are sampled once per frame, at the start-bit boundary.

Top module: `emb_clk_framer`

## Requirements
- R1: While rst_ni is low, ser_o is low, whatever bit_en_i does.
- R2: A frame is 12 bits sent in this order: a start bit of 1, data bits 0 through 9 (LSB first), then a stop bit of 0. Each enabled cycle sends one bit.
- R3: The first bit enable after reset is released sends a start bit. This also holds when reset interrupts a frame part way through.
- R4: ser_o changes only on a clock edge where bit_en_i is high. With bit_en_i low, ser_o and the frame position hold.
- R5: If sync_a_i is high at a frame boundary, the frame carries the sync data field 10'b0000011111. Sent LSB first, the whole frame is 1,1,1,1,1,1,0,0,0,0,0,0.
- R6: While a sync request stays high, every frame is a sync frame, back to back, with no gap.
- R7: data_i and both sync requests are sampled only on the enabled cycle that sends the start bit. Changes made later in the frame take effect in the next frame.
- R8: sync_b_i has the same effect as sync_a_i, and both high together also give a sync frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word/bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Bit-rate enable: one serial bit per enabled cycle |
| data_i | input | 10 | Parallel word, sampled at the frame boundary |
| sync_a_i | input | 1 | Sync request A |
| sync_b_i | input | 1 | Sync request B |
| ser_o | output | 1 | Serial framed bit stream |

## Verification
The hardest case to reach from the ports is a change to the word or sync inputs in the middle of a frame. The bench meets it on every frame: right after the start bit goes out, it inverts the data word and flips both sync requests, then checks that the frame on the wire still carries the values from the boundary. Enable gaps of several idle cycles between bits, and a reset that cuts a frame short, reach the hold and restart behaviour. The data sweep covers all 1024 words.

// File: rtl/emb_framer_pkg.sv
package emb_framer_pkg;
  localparam logic START_BIT = 1'b1;
  localparam logic STOP_BIT  = 1'b0;

  function automatic int unsigned frame_len(input int unsigned word_w);
    return word_w + 2;
  endfunction
endpackage

// File: rtl/framer_pos_ctr.sv
module framer_pos_ctr #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic start_o,
  output logic last_o
);
  localparam int unsigned POS_W = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (bit_en_i) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
  end

  assign start_o = bit_en_i && (pos_q == '0);
  assign last_o  = bit_en_i && (pos_q == LAST_POS);
endmodule

// File: rtl/framer_word_sel.sv
module framer_word_sel
  import emb_framer_pkg::*;
#(
  parameter int unsigned          WORD_W    = 10,
  parameter logic [WORD_W-1:0]    SYNC_WORD = 10'b0000011111,
  localparam int unsigned         FRAME_W   = WORD_W + 2
) (
  input  logic [WORD_W-1:0]  data_i,
  input  logic               sync_a_i,
  input  logic               sync_b_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [WORD_W-1:0] payload;

  always_comb begin
    payload = (sync_a_i || sync_b_i) ? SYNC_WORD : data_i;
    frame_o = {STOP_BIT, payload, START_BIT};
  end
endmodule

// File: rtl/framer_shifter.sv
module framer_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o,
  output logic [FRAME_W-2:0] rest_o
);
  logic               ser_q;
  logic [FRAME_W-2:0] rest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q  <= 1'b0;
      rest_q <= '0;
    end else if (bit_en_i) begin
      if (load_i) begin
        ser_q  <= frame_i[0];
        rest_q <= frame_i[FRAME_W-1:1];
      end else begin
        ser_q  <= rest_q[0];
        rest_q <= {1'b0, rest_q[FRAME_W-2:1]};
      end
    end
  end

  assign ser_o  = ser_q;
  assign rest_o = rest_q;
endmodule

// File: rtl/emb_clk_framer.sv
module emb_clk_framer
  import emb_framer_pkg::*;
#(
  parameter int unsigned       WORD_W    = 10,
  parameter logic [WORD_W-1:0] SYNC_WORD = 10'b0000011111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  output logic              ser_o
);
  localparam int unsigned FRAME_W = frame_len(WORD_W);

  logic               frame_start;
  logic               frame_last;
  logic [FRAME_W-1:0] frame_vec;
  logic [FRAME_W-2:0] frame_rest;

  framer_pos_ctr #(.FRAME_W(FRAME_W)) i_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .start_o  (frame_start),
    .last_o   (frame_last)
  );

  framer_word_sel #(.WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)) i_sel (
    .data_i   (data_i),
    .sync_a_i (sync_a_i),
    .sync_b_i (sync_b_i),
    .frame_o  (frame_vec)
  );

  framer_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .load_i   (frame_start),
    .frame_i  (frame_vec),
    .ser_o    (ser_o),
    .rest_o   (frame_rest)
  );
endmodule

// File: rtl/framer_checks.sv
module framer_checks
  import emb_framer_pkg::*;
#(
  parameter int unsigned       WORD_W    = 10,
  parameter logic [WORD_W-1:0] SYNC_WORD = 10'b0000011111,
  localparam int unsigned      FRAME_W   = WORD_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_en_i,
  input logic               sync_a_i,
  input logic               sync_b_i,
  input logic               ser_o,
  input logic               start_i,
  input logic               last_i,
  input logic [FRAME_W-2:0] rest_i
);
  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !ser_o);

  a_r2_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ser_o);

  a_r2_stop_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> !ser_o);

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(ser_o) && $stable(rest_i));

  a_r5_sync_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (sync_a_i || sync_b_i) |=> rest_i == {STOP_BIT, SYNC_WORD});
endmodule

bind emb_clk_framer framer_checks #(.WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)) i_checks (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .sync_a_i (sync_a_i),
  .sync_b_i (sync_b_i),
  .ser_o    (ser_o),
  .start_i  (frame_start),
  .last_i   (frame_last),
  .rest_i   (frame_rest)
);

// File: tb/test_emb_clk_framer.sv
`timescale 1ns/1ps
module test_emb_clk_framer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic [9:0] data_i = '0;
  logic       sync_a_i = 1'b0;
  logic       sync_b_i = 1'b0;
  logic       ser_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  emb_clk_framer i_emb_clk_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .data_i   (data_i),
    .sync_a_i (sync_a_i),
    .sync_b_i (sync_b_i),
    .ser_o    (ser_o)
  );

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Sends one frame; inputs are inverted after the start bit to probe R7.
  task automatic run_frame(input logic [9:0] d, input logic sa, input logic sb,
                           input int gap, input string req);
    logic [11:0] exp;
    logic [11:0] got;
    bit          hold_bad;
    exp = {1'b0, (sa | sb) ? 10'b0000011111 : d, 1'b1};
    got = '0;
    hold_bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (k == 0) begin
        data_i = d; sync_a_i = sa; sync_b_i = sb;
      end else if (k == 1) begin
        data_i = ~d; sync_a_i = ~sa; sync_b_i = ~sb;
      end
      bit_en_i = 1'b1;
      @(negedge clk_i);
      got[k] = ser_o;
      bit_en_i = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_i);
        if (ser_o !== got[k]) hold_bad = 1'b1;
      end
    end
    check(got === exp, req, got, exp);
    if (gap > 0) check(!hold_bad, "R4", {11'b0, hold_bad}, 12'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: output low in reset while enables toggle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      bit_en_i = ~bit_en_i;
      check(ser_o === 1'b0, "R1", {11'b0, ser_o}, 12'b0);
    end
    @(negedge clk_i);
    bit_en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(ser_o === 1'b0, "R4", {11'b0, ser_o}, 12'b0);

    // R3: first enable after reset sends the start bit
    run_frame(10'h2A5, 1'b0, 1'b0, 0, "R3");

    // R2 sweep over every word, R7 mid-frame change on each, gaps on some
    for (int d = 0; d < 1024; d++)
      run_frame(10'(d), 1'b0, 1'b0, (d % 8 == 3) ? 2 : 0, "R2");

    // R5 sync via input A
    run_frame(10'h3C3, 1'b1, 1'b0, 0, "R5");
    run_frame(10'h000, 1'b1, 1'b0, 3, "R5");
    // R8 sync via input B and both together
    run_frame(10'h155, 1'b0, 1'b1, 0, "R8");
    run_frame(10'h2AA, 1'b1, 1'b1, 1, "R8");
    // R6 sustained sync, back to back
    for (int i = 0; i < 4; i++) run_frame(10'(i * 77), 1'b0, 1'b1, 0, "R6");
    // R7 data returns right after sync ends
    run_frame(10'h3FF, 1'b0, 1'b0, 0, "R7");
    run_frame(10'h001, 1'b0, 1'b0, 0, "R7");

    // R3: reset cutting a frame part way
    data_i = 10'h0F0;
    for (int k = 0; k < 5; k++) begin
      bit_en_i = 1'b1;
      @(negedge clk_i);
    end
    bit_en_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1 check(ser_o === 1'b0, "R1", {11'b0, ser_o}, 12'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_frame(10'h0F0, 1'b0, 1'b0, 0, "R3");
    run_frame(10'h30C, 1'b0, 1'b0, 0, "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule